// File: doc/BRIEF.md
# Serial Frame Longitudinal Check Generator

This block computes the longitudinal check byte of a text-mode serial frame. The frame bytes arrive on a byte stream, one per accepted transfer. The first byte is the address byte and the last is the final data byte. Each byte has already been converted from its pair of hex characters, and delimiter characters never reach this block. The block keeps a running sum modulo 256 with the carry dropped. When the byte marked as last is accepted, it latches the two's-complement negation of that sum as the check byte.

The check byte is presented in two forms: as a binary value, and as a pair of uppercase ASCII hex characters packed with the high-nibble character in the upper byte, so the character to send first is in the upper byte. In check mode, which is selected together with the last byte, the block also takes a received check byte and raises a mismatch flag when the frame sum plus that byte is not zero modulo 256.

Back-pressure rules: the byte input is a valid/ready stream. A byte is taken on a rising clock edge where both `byte_valid_i` and `byte_ready_o` are high. Ready is low only during reset and in the first edge after reset, and is high at all other times, so a sender never waits more than that. The sideband inputs `first_i`, `last_i`, `chk_mode_i` and `rx_chk_i` are sampled only with an accepted byte. The result side is a plain one-cycle pulse with held data; there is no handshake.

Top module: `lrc_frame_gen`

## Requirements
- R1: During and directly after reset, `res_valid_o` and `mismatch_o` are 0, `res_byte_o` is 00h and `res_text_o` is 3030h (two '0' characters).
- R2: `byte_ready_o` is high in every cycle after the first clock edge that follows reset release.
- R3: The check byte is 00h minus the sum modulo 256 of all accepted bytes of the frame, with every carry out of bit 7 discarded. Example: 01h,03h,21h,02h,00h,02h gives D7h, and FFh,FFh gives 02h.
- R4: A byte accepted with `first_i` high restarts the sum at that byte's own value, even when it arrives in the middle of a frame.
- R5: `res_valid_o` is high for exactly the one cycle after a byte with `last_i` high is accepted. `res_byte_o`, `res_text_o` and `mismatch_o` update in that cycle and hold until the next result.
- R6: After a last byte, the sum returns to zero, so the next frame is correct without `first_i`.
- R7: `res_text_o[15:8]` encodes the high nibble and `res_text_o[7:0]` the low nibble. Values 0 to 9 map to 30h to 39h, and values 10 to 15 map to 41h to 46h ('A' to 'F').
- R8: With `chk_mode_i` high on the last byte, `mismatch_o` is 1 when (frame sum + `rx_chk_i`) mod 256 is not 00h, and 0 otherwise. With `chk_mode_i` low it is 0.
- R9: Bytes presented while `byte_valid_i` is low are ignored and change neither the sum nor the outputs.
- R10: A byte with both `first_i` and `last_i` high forms a one-byte frame whose check byte is the negation of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Frame byte is present |
| byte_ready_o | output | 1 | Block can take a byte |
| byte_data_i | input | 8 | Decoded frame byte |
| first_i | input | 1 | Byte opens a frame (sum restarts) |
| last_i | input | 1 | Byte closes a frame (result latched) |
| chk_mode_i | input | 1 | Compare against `rx_chk_i` for this frame |
| rx_chk_i | input | 8 | Received check byte, sampled with the last byte |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_byte_o | output | 8 | Check byte, binary |
| res_text_o | output | 16 | Check byte as two ASCII hex characters, high nibble in the upper byte |
| mismatch_o | output | 1 | Received check byte disagrees with the frame |

## Verification
Opening a frame and closing it can fall on the same accepted byte, when `first_i` and `last_i` are both high. In that case the restart of the sum and the latching of the result must both act in one edge. The bench sends such one-byte frames on purpose, in the middle of a partly summed frame and directly after another result pulse. It also lets random stimulus raise both flags together. It then judges the pulse, the check byte and the mismatch flag against a model in which the restart is applied before the byte is added.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  // ASCII code for one hex digit, uppercase letters
  function automatic logic [7:0] hex_char(input logic [3:0] nib);
    logic [7:0] code;
    if (nib < 4'd10) code = 8'h30 + {4'h0, nib};
    else             code = 8'h37 + {4'h0, nib};
    return code;
  endfunction

endpackage

// File: rtl/lrc_accum.sv
module lrc_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic         first_i,
  input  logic         last_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sum_next_o
);

  logic [W-1:0] acc_q;
  logic [W-1:0] base;

  // restart applies before the byte is added; carry out of the top bit is lost
  assign base       = first_i ? '0 : acc_q;
  assign sum_next_o = base + data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (take_i) begin
      acc_q <= last_i ? '0 : sum_next_o;
    end
  end

endmodule

// File: rtl/lrc_result.sv
module lrc_result #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic         last_i,
  input  logic         mode_i,
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] sum_i,
  output logic         valid_o,
  output logic [W-1:0] chk_o,
  output logic         mis_o
);

  logic [W-1:0] neg_sum;
  logic [W-1:0] total;
  logic         close;

  assign close   = take_i & last_i;
  assign neg_sum = '0 - sum_i;
  assign total   = sum_i + rx_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      chk_o   <= '0;
      mis_o   <= 1'b0;
    end else begin
      valid_o <= close;
      if (close) begin
        chk_o <= neg_sum;
        mis_o <= mode_i & (total != '0);
      end
    end
  end

endmodule

// File: rtl/lrc_hex_enc.sv
module lrc_hex_enc #(
  parameter int W = 8
) (
  input  logic [W-1:0]       val_i,
  output logic [2*W-1:0]     text_o
);

  import lrc_pkg::*;

  localparam int NCHR = W / 4;

  // nibble k lands in character slot k; the top nibble is sent first
  for (genvar k = 0; k < NCHR; k++) begin : g_nib
    assign text_o[8*k +: 8] = hex_char(val_i[4*k +: 4]);
  end

endmodule

// File: rtl/lrc_frame_gen.sv
module lrc_frame_gen #(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid_i,
  output logic          byte_ready_o,
  input  logic [W-1:0]  byte_data_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic          chk_mode_i,
  input  logic [W-1:0]  rx_chk_i,
  output logic          res_valid_o,
  output logic [W-1:0]  res_byte_o,
  output logic [2*W-1:0] res_text_o,
  output logic          mismatch_o
);

  logic         ready_q;
  logic         take;
  logic [W-1:0] sum_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign byte_ready_o = ready_q;
  assign take         = byte_valid_i & ready_q;

  lrc_accum #(.W(W)) accum_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .first_i    (first_i),
    .last_i     (last_i),
    .data_i     (byte_data_i),
    .sum_next_o (sum_next)
  );

  lrc_result #(.W(W)) result_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .last_i  (last_i),
    .mode_i  (chk_mode_i),
    .rx_i    (rx_chk_i),
    .sum_i   (sum_next),
    .valid_o (res_valid_o),
    .chk_o   (res_byte_o),
    .mis_o   (mismatch_o)
  );

  lrc_hex_enc #(.W(W)) enc_i (
    .val_i  (res_byte_o),
    .text_o (res_text_o)
  );

endmodule

// File: rtl/lrc_frame_gen_chk.sv
module lrc_frame_gen_chk #(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_valid_i,
  input logic          byte_ready_o,
  input logic          first_i,
  input logic          last_i,
  input logic          chk_mode_i,
  input logic [W-1:0]  rx_chk_i,
  input logic [W-1:0]  sum_next,
  input logic          res_valid_o,
  input logic [W-1:0]  res_byte_o,
  input logic [2*W-1:0] res_text_o,
  input logic          mismatch_o
);

  logic take;
  assign take = byte_valid_i & byte_ready_o;

  // R2: ready stays up once a clock edge has passed out of reset
  a_r2_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> byte_ready_o);

  // R5: a closing byte is followed by the pulse
  a_r5_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_i) |=> res_valid_o);

  // R5: no pulse without a closing byte one cycle before
  a_r5_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!(take && last_i)) |=> !res_valid_o);

  // R5: result data holds between pulses
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> ($stable(res_byte_o) && $stable(mismatch_o)));

  // R7: each character is a legal uppercase hex code
  a_r7_text_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_text_o[15:8] inside {[8'h30:8'h39], [8'h41:8'h46]}) &&
     (res_text_o[7:0]  inside {[8'h30:8'h39], [8'h41:8'h46]})));

  // R8: compare mode off never flags
  a_r8_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_i && !chk_mode_i) |=> !mismatch_o);

  // R8: a received byte that balances the sum never flags
  a_r8_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_i && (W'(sum_next + rx_chk_i) == '0)) |=> !mismatch_o);

  // R3: the latched check byte balances the frame sum
  a_r3_negation: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_i) |=> (W'(res_byte_o + $past(sum_next)) == '0));

endmodule

bind lrc_frame_gen lrc_frame_gen_chk #(.W(W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .first_i      (first_i),
  .last_i       (last_i),
  .chk_mode_i   (chk_mode_i),
  .rx_chk_i     (rx_chk_i),
  .sum_next     (sum_next),
  .res_valid_o  (res_valid_o),
  .res_byte_o   (res_byte_o),
  .res_text_o   (res_text_o),
  .mismatch_o   (mismatch_o)
);

// File: tb/lrc_frame_gen_tb_top.sv
module lrc_frame_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic        byte_ready_o;
  logic [7:0]  byte_data_i = '0;
  logic        first_i = 1'b0;
  logic        last_i = 1'b0;
  logic        chk_mode_i = 1'b0;
  logic [7:0]  rx_chk_i = '0;
  logic        res_valid_o;
  logic [7:0]  res_byte_o;
  logic [15:0] res_text_o;
  logic        mismatch_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m_acc = '0;
  logic [7:0] m_res = '0;
  logic       m_mis = 1'b0;
  logic       m_pulse = 1'b0;

  always #2 clk = ~clk;

  lrc_frame_gen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .byte_data_i  (byte_data_i),
    .first_i      (first_i),
    .last_i       (last_i),
    .chk_mode_i   (chk_mode_i),
    .rx_chk_i     (rx_chk_i),
    .res_valid_o  (res_valid_o),
    .res_byte_o   (res_byte_o),
    .res_text_o   (res_text_o),
    .mismatch_o   (mismatch_o)
  );

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 10) ? (8'd48 + 8'(n)) : (8'd55 + 8'(n));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at a falling edge, compare at the next falling edge
  task automatic step(input bit v, input logic [7:0] d, input bit f, input bit l,
                      input bit md, input logic [7:0] rx, input string tag);
    logic [7:0] s;
    byte_valid_i = v; byte_data_i = d; first_i = f; last_i = l;
    chk_mode_i = md; rx_chk_i = rx;
    m_pulse = 1'b0;
    if (v) begin
      s = (f ? 8'h00 : m_acc) + d;
      if (l) begin
        m_res = 8'h00 - s;
        m_mis = md && (8'(s + rx) != 8'h00);
        m_acc = 8'h00;
        m_pulse = 1'b1;
      end else begin
        m_acc = s;
      end
    end
    @(negedge clk);
    byte_valid_i = 1'b0;
    chk("R2 ready", 32'(byte_ready_o), 32'd1);
    chk("R5 pulse", 32'(res_valid_o), 32'(m_pulse));
    chk(tag, 32'(res_byte_o), 32'(m_res));
    chk("R7 text", 32'(res_text_o), {16'h0, hx(m_res[7:4]), hx(m_res[3:0])});
    chk("R8 mismatch", 32'(mismatch_o), 32'(m_mis));
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h5A, 1'b1, 1'b1, 1'b1, 8'h11, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ex[6];
    ex = '{8'h01, 8'h03, 8'h21, 8'h02, 8'h00, 8'h02};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 valid", 32'(res_valid_o), 0);
    chk("R1 byte", 32'(res_byte_o), 0);
    chk("R1 text", 32'(res_text_o), 32'h3030);
    chk("R1 mismatch", 32'(mismatch_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 32'(res_valid_o), 0);

    // R3: worked example, no first flag after reset
    for (int i = 0; i < 6; i++) step(1'b1, ex[i], 1'b0, i == 5, 1'b0, 8'h00, "R3 example");
    chk("R3 D7", 32'(res_byte_o), 32'hD7);
    chk("R7 D7 text", 32'(res_text_o), 32'h4437);
    idle("R5 hold");

    // R8: matching and mismatching received byte
    for (int i = 0; i < 6; i++) step(1'b1, ex[i], i == 0, i == 5, 1'b1, 8'hD7, "R8 match");
    chk("R8 match flag", 32'(mismatch_o), 0);
    for (int i = 0; i < 6; i++) step(1'b1, ex[i], i == 0, i == 5, 1'b1, 8'hD8, "R8 wrong");
    chk("R8 wrong flag", 32'(mismatch_o), 1);

    // R3: carry discarded
    step(1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h00, "R3 carry");
    step(1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00, "R3 carry");
    chk("R3 carry 02", 32'(res_byte_o), 32'h02);

    // R9: invalid bytes in mid-frame are ignored
    step(1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 8'h00, "R9 gap");
    idle("R9 gap");
    idle("R9 gap");
    step(1'b1, 8'h20, 1'b0, 1'b1, 1'b0, 8'h00, "R9 gap");
    chk("R9 D0", 32'(res_byte_o), 32'hD0);

    // R4: restart in mid-frame
    step(1'b1, 8'h44, 1'b1, 1'b0, 1'b0, 8'h00, "R4 restart");
    step(1'b1, 8'h05, 1'b1, 1'b0, 1'b0, 8'h00, "R4 restart");
    step(1'b1, 8'h03, 1'b0, 1'b1, 1'b0, 8'h00, "R4 restart");
    chk("R4 F8", 32'(res_byte_o), 32'hF8);

    // R10: one-byte frames, one after a partial sum, then back to back
    step(1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 8'h00, "R10 single");
    step(1'b1, 8'h01, 1'b1, 1'b1, 1'b1, 8'hFF, "R10 single");
    chk("R10 FF", 32'(res_byte_o), 32'hFF);
    step(1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h01, "R10 zero");
    chk("R10 zero text", 32'(res_text_o), 32'h3030);

    // R6: next frame without first flag starts from zero
    step(1'b1, 8'h0A, 1'b0, 1'b1, 1'b0, 8'h00, "R6 fresh");
    chk("R6 F6", 32'(res_byte_o), 32'hF6);

    // random stimulus against the model
    for (int n = 0; n < 3000; n++) begin
      bit v, f, l, md;
      logic [7:0] d, rx, s;
      v  = ($urandom % 4) != 0;
      f  = ($urandom % 10) == 0;
      l  = ($urandom % 7) == 0;
      md = $urandom % 2;
      d  = 8'($urandom);
      s  = (f ? 8'h00 : m_acc) + d;
      rx = ($urandom % 2) ? (8'h00 - s) : 8'($urandom);
      step(v, d, f, l, md, rx, "R3 random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule